// File: doc/BRIEF.md
# Main Clock Loss Monitor with Automatic Failover

This block keeps the core clocked when the main oscillator fails. A free-running backup oscillator clocks a small monitor that watches for rising edges of the main clock. When the edges stop for a fixed number of backup cycles, the core clock output is moved onto the backup oscillator through a glitch-free multiplexer. A sticky status flag records the event, and an optional interrupt is raised. Once the main clock has produced a steady run of edges again, the core clock returns to it with no software involvement.

Software reaches the block through a three-bit register port. Bit 0 is the loss flag, cleared by writing 1, and only while the main clock is in use. Bit 1 is the interrupt enable. Bit 2 is read-only and shows which clock is selected. A halt input freezes the monitor and its register, and a wait input lets a pending loss interrupt produce a wake request. All logic on the register side runs on the backup clock and uses a synchronous active-high reset.

Top module: `clkmon_failover`

## Requirements
- R1: When the main clock shows no rising edge for LOSS_CYC (default 8) consecutive backup-clock cycles after synchronization, the selection moves to the backup clock: read bit 2 becomes 1 and clk_core then follows clk_bkp.
- R2: The loss flag (read bit 0) becomes 1 in the same cycle that the backup clock is selected, and it stays 1 for as long as the backup clock is selected.
- R3: While the backup clock is selected, RECOV_EDGES (default 16) main-clock rising edges in a row, each arriving within LOSS_CYC backup cycles of the one before, return the selection to the main clock (read bit 2 becomes 0). No register write is needed, and clk_core then follows clk_main.
- R4: Writing 1 to bit 0 clears the loss flag only while the main clock is selected. The same write made while the backup clock is selected has no effect.
- R5: A loss event makes an interrupt pending only if the enable (bit 1) was already 1 when the event occurred. Setting the enable later does not raise irq_o for that event. Clearing the flag or clearing the enable removes the pending state.
- R6: irq_o is high one cycle after a pending interrupt is present with irq_mask_i low. It is low one cycle after irq_mask_i is high.
- R7: wake_o goes high one cycle after wait_i is high with an interrupt pending and halt_i low. wake_o is always low in the cycle after halt_i is high.
- R8: While halt_i is high, the monitor state and the register contents are frozen. A stopped main clock causes no switch and no flag change, register writes are ignored, and the earlier configuration is still in place after halt_i falls.
- R9: Reset, including a reset applied during halt, clears the flag and the enable, and selects the main clock (read value 3'b000).
- R10: The two clock-gate enables are never high together, so clk_core never carries pulses from both clocks at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bkp | input | 1 | Free-running backup oscillator; clocks the monitor and registers |
| clk_main | input | 1 | Main oscillator being monitored |
| rst | input | 1 | Synchronous active-high reset (backup clock domain) |
| halt_i | input | 1 | Halt mode: freezes monitor and register state |
| wait_i | input | 1 | Wait mode: enables the wake request |
| irq_mask_i | input | 1 | Global interrupt mask; high blocks irq_o |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 3 | Write data: bit 0 clear flag (W1C), bit 1 interrupt enable |
| reg_rdata | output | 3 | Read data: bit 0 flag, bit 1 enable, bit 2 backup selected |
| clk_core | output | 1 | Glitch-free selected core clock |
| irq_o | output | 1 | Clock-loss interrupt request |
| wake_o | output | 1 | Wake request out of wait mode |

## Verification
The bench stops the main clock while it is held low and expects the switch, the flag and the interrupt. A detector with a wrong timeout would never switch, or would switch while the clock is still running. It tries to clear the flag while on the backup clock, and a design that honours that write loses the record of the event. It turns the enable on only after a loss, which catches a design that raises the interrupt from the level of the enable. It also stops the main clock during halt, and any design that keeps monitoring in halt would switch clocks there and set the flag.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
  localparam int REG_W     = 3;
  localparam int BIT_FLAG  = 0;
  localparam int BIT_IE    = 1;
  localparam int BIT_SRC   = 2;

  typedef struct packed {
    logic sel_bkp;
    logic loss_evt;
  } mon_out_t;
endpackage

// File: rtl/clkmon_detect.sv
module clkmon_detect #(
  parameter int LOSS_CYC    = 8,
  parameter int RECOV_EDGES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_bkp,
  input  logic clk_main,
  input  logic rst,
  input  logic rst_a,
  input  logic halt_i,
  output clkmon_pkg::mon_out_t mon_o
);
  localparam int GAP_W = $clog2(LOSS_CYC + 1);
  localparam int RC_W  = $clog2(RECOV_EDGES + 1);

  logic                 tgl;
  logic [SYNC_STAGES:0] smp;
  logic [GAP_W-1:0]     gap_cnt;
  logic [RC_W-1:0]      rec_cnt;
  logic                 sel_bkp;
  logic                 edge_seen;
  logic                 timeout;

  // main-domain edge marker: flips on every rising edge of the main clock
  always_ff @(posedge clk_main or posedge rst_a) begin
    if (rst_a) tgl <= 1'b0;
    else       tgl <= ~tgl;
  end

  always_ff @(posedge clk_bkp) begin
    if (rst)          smp <= '0;
    else if (!halt_i) smp <= {smp[SYNC_STAGES-1:0], tgl};
  end

  assign edge_seen = smp[SYNC_STAGES] ^ smp[SYNC_STAGES-1];
  assign timeout   = !edge_seen && (gap_cnt == GAP_W'(LOSS_CYC - 1));

  always_ff @(posedge clk_bkp) begin
    if (rst) begin
      gap_cnt <= '0;
      rec_cnt <= '0;
      sel_bkp <= 1'b0;
    end else if (!halt_i) begin
      if (edge_seen || timeout) gap_cnt <= '0;
      else                      gap_cnt <= gap_cnt + 1'b1;
      if (!sel_bkp) begin
        rec_cnt <= '0;
        if (timeout) sel_bkp <= 1'b1;
      end else if (timeout) begin
        rec_cnt <= '0;
      end else if (edge_seen) begin
        if (rec_cnt == RC_W'(RECOV_EDGES - 1)) begin
          rec_cnt <= '0;
          sel_bkp <= 1'b0;
        end else begin
          rec_cnt <= rec_cnt + 1'b1;
        end
      end
    end
  end

  assign mon_o.sel_bkp  = sel_bkp;
  assign mon_o.loss_evt = !halt_i && !sel_bkp && timeout;

  p_gap_bound_r1: assert property (@(posedge clk_bkp) disable iff (rst)
    gap_cnt < GAP_W'(LOSS_CYC));
  p_loss_switch_r1: assert property (@(posedge clk_bkp) disable iff (rst)
    mon_o.loss_evt |=> sel_bkp);
  p_halt_sel_r8: assert property (@(posedge clk_bkp) disable iff (rst)
    halt_i |=> $stable(sel_bkp));
endmodule

// File: rtl/clkmon_regs.sv
module clkmon_regs
  import clkmon_pkg::*;
(
  input  logic             clk_bkp,
  input  logic             rst,
  input  logic             halt_i,
  input  logic             wait_i,
  input  logic             irq_mask_i,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  input  mon_out_t         mon_i,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq_o,
  output logic             wake_o
);
  logic flag, ie, pend;
  logic clr_req;

  assign clr_req = reg_we && reg_wdata[BIT_FLAG] && !mon_i.sel_bkp;

  always_ff @(posedge clk_bkp) begin
    if (rst) begin
      flag   <= 1'b0;
      ie     <= 1'b0;
      pend   <= 1'b0;
      irq_o  <= 1'b0;
      wake_o <= 1'b0;
    end else if (!halt_i) begin
      if (reg_we) ie <= reg_wdata[BIT_IE];
      if (mon_i.loss_evt) begin
        flag <= 1'b1;
        pend <= ie;
      end else begin
        if (clr_req) flag <= 1'b0;
        if (clr_req || (reg_we && !reg_wdata[BIT_IE])) pend <= 1'b0;
      end
      irq_o  <= pend && !irq_mask_i;
      wake_o <= pend && wait_i;
    end else begin
      irq_o  <= 1'b0;
      wake_o <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata          = '0;
    reg_rdata[BIT_FLAG] = flag;
    reg_rdata[BIT_IE]   = ie;
    reg_rdata[BIT_SRC]  = mon_i.sel_bkp;
  end

  p_flag_on_bkp_r2: assert property (@(posedge clk_bkp) disable iff (rst)
    mon_i.sel_bkp |-> flag);
  p_irq_mask_r6: assert property (@(posedge clk_bkp) disable iff (rst)
    irq_o |-> $past(!irq_mask_i));
  p_wake_halt_r7: assert property (@(posedge clk_bkp) disable iff (rst)
    halt_i |=> !wake_o && !irq_o);
  p_halt_flag_r8: assert property (@(posedge clk_bkp) disable iff (rst)
    halt_i |=> $stable(flag) && $stable(ie));
endmodule

// File: rtl/clkmon_mux.sv
module clkmon_mux #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_bkp,
  input  logic clk_main,
  input  logic rst,
  input  logic rst_a,
  input  logic sel_bkp,
  output logic clk_core
);
  logic                   kill;
  logic [SYNC_STAGES-1:0] m_sync;
  logic [SYNC_STAGES-1:0] b_sync;
  logic                   en_main, en_bkp;

  // a selected backup clock means the main clock is dead: drop its gate at once
  assign kill = rst_a || sel_bkp;

  always_ff @(posedge clk_main or posedge kill) begin
    if (kill) m_sync <= '0;
    else      m_sync <= {m_sync[SYNC_STAGES-2:0], ~en_bkp};
  end

  always_ff @(negedge clk_main or posedge kill) begin
    if (kill) en_main <= 1'b0;
    else      en_main <= m_sync[SYNC_STAGES-1];
  end

  always_ff @(posedge clk_bkp) begin
    if (rst) b_sync <= '0;
    else     b_sync <= {b_sync[SYNC_STAGES-2:0], sel_bkp & ~en_main};
  end

  always_ff @(negedge clk_bkp) begin
    if (rst) en_bkp <= 1'b0;
    else     en_bkp <= b_sync[SYNC_STAGES-1];
  end

  assign clk_core = (clk_main & en_main) | (clk_bkp & en_bkp);

  p_gate_excl_r10: assert property (@(posedge clk_bkp) disable iff (rst)
    !(en_main && en_bkp));
  p_bkp_gate_r10: assert property (@(posedge clk_bkp) disable iff (rst)
    en_bkp |-> !en_main);
endmodule

// File: rtl/clkmon_failover.sv
module clkmon_failover
  import clkmon_pkg::*;
#(
  parameter int LOSS_CYC    = 8,
  parameter int RECOV_EDGES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_bkp,
  input  logic             clk_main,
  input  logic             rst,
  input  logic             halt_i,
  input  logic             wait_i,
  input  logic             irq_mask_i,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             clk_core,
  output logic             irq_o,
  output logic             wake_o
);
  logic     rst_a;
  mon_out_t mon;

  // registered copy of reset used as the asynchronous clear of main-domain flops
  always_ff @(posedge clk_bkp) rst_a <= rst;

  clkmon_detect #(
    .LOSS_CYC(LOSS_CYC), .RECOV_EDGES(RECOV_EDGES), .SYNC_STAGES(SYNC_STAGES)
  ) u_detect (
    .clk_bkp(clk_bkp), .clk_main(clk_main), .rst(rst), .rst_a(rst_a),
    .halt_i(halt_i), .mon_o(mon)
  );

  clkmon_regs u_regs (
    .clk_bkp(clk_bkp), .rst(rst), .halt_i(halt_i), .wait_i(wait_i),
    .irq_mask_i(irq_mask_i), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .mon_i(mon), .reg_rdata(reg_rdata), .irq_o(irq_o), .wake_o(wake_o)
  );

  clkmon_mux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
    .clk_bkp(clk_bkp), .clk_main(clk_main), .rst(rst), .rst_a(rst_a),
    .sel_bkp(mon.sel_bkp), .clk_core(clk_core)
  );
endmodule

// File: tb/clkmon_failover_tb.sv
`timescale 1ns/1ps
module clkmon_failover_tb;
  logic       clk_bkp = 1'b0;
  logic       clk_main = 1'b0;
  logic       main_run = 1'b1;
  logic       rst = 1'b1;
  logic       halt_i = 1'b0, wait_i = 1'b0, irq_mask_i = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_wdata = 3'b000;
  logic [2:0] reg_rdata;
  logic       clk_core, irq_o, wake_o;

  int checks = 0, errors = 0;
  int mon_checks = 0, mon_errors = 0;
  int wd_err = 0;
  logic done = 1'b0;
  logic smp = 1'b0;

  logic [2:0] exp_q[$];
  string      tag_q[$];

  clkmon_failover u_dut (
    .clk_bkp(clk_bkp), .clk_main(clk_main), .rst(rst), .halt_i(halt_i),
    .wait_i(wait_i), .irq_mask_i(irq_mask_i), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_core(clk_core),
    .irq_o(irq_o), .wake_o(wake_o)
  );

  always #4 clk_bkp = ~clk_bkp;

  initial begin
    forever begin
      if (main_run) begin
        #12 clk_main = 1'b1;
        #12 clk_main = 1'b0;
      end else begin
        #4;
      end
    end
  end

  // monitor: pops expected register values and compares at the falling edge
  always @(negedge clk_bkp) begin
    if (smp && exp_q.size() > 0) begin
      automatic logic [2:0] e = exp_q.pop_front();
      automatic string      t = tag_q.pop_front();
      mon_checks++;
      if (reg_rdata !== e) begin
        mon_errors++;
        $display("FAIL %s rdata act=%b exp=%b", t, reg_rdata, e);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk_bkp);
    #1;
  endtask

  task automatic wr(input logic [2:0] d);
    @(posedge clk_bkp); #1 reg_we = 1'b1; reg_wdata = d;
    @(posedge clk_bkp); #1 reg_we = 1'b0; reg_wdata = 3'b000;
  endtask

  task automatic expect_rd(input logic [2:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(posedge clk_bkp); #1 smp = 1'b1;
    @(posedge clk_bkp); #1 smp = 1'b0;
  endtask

  task automatic chk(input logic act, input logic e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s act=%b exp=%b", t, act, e);
    end
  endtask

  task automatic chk_core_bkp(input string t);
    @(posedge clk_bkp); #2 chk(clk_core, 1'b1, t);
    @(negedge clk_bkp); #2 chk(clk_core, 1'b0, t);
  endtask

  task automatic chk_core_main(input string t);
    @(posedge clk_main); #2 chk(clk_core, 1'b1, t);
    @(negedge clk_main); #2 chk(clk_core, 1'b0, t);
  endtask

  task automatic stop_main;
    main_run = 1'b0;
    wait (clk_main == 1'b0);
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks + mon_checks + wd_err,
               errors + mon_errors + wd_err);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      wd_err = 1;
      $display("FAIL watchdog act=running exp=finished");
      report();
    end
  end

  initial begin
    cyc(6);
    rst = 1'b0;
    cyc(6);
    // R9: reset state
    expect_rd(3'b000, "R9 reset value");
    chk(irq_o, 1'b0, "R9 irq after reset");
    chk_core_main("R10 core on main after reset");

    wr(3'b010);
    expect_rd(3'b010, "R5 enable set");

    // R1/R2: loss with enable set beforehand
    stop_main();
    cyc(30);
    expect_rd(3'b111, "R1 R2 switch and flag");
    chk(irq_o, 1'b1, "R5 irq on loss with enable");
    chk_core_bkp("R1 core follows backup");

    // R6: mask
    irq_mask_i = 1'b1;
    cyc(2);
    chk(irq_o, 1'b0, "R6 masked irq");
    irq_mask_i = 1'b0;
    cyc(2);
    chk(irq_o, 1'b1, "R6 unmasked irq");

    // R7: wake from wait
    wait_i = 1'b1;
    cyc(2);
    chk(wake_o, 1'b1, "R7 wake in wait");
    wait_i = 1'b0;
    cyc(2);
    chk(wake_o, 1'b0, "R7 no wake without wait");

    // R4: clear ignored on backup
    wr(3'b011);
    expect_rd(3'b111, "R4 clear ignored on backup");

    // R3: recovery
    main_run = 1'b1;
    cyc(100);
    expect_rd(3'b011, "R3 auto return flag kept");
    chk_core_main("R3 core follows main");

    // R4: clear on main
    wr(3'b011);
    expect_rd(3'b010, "R4 clear on main");
    cyc(2);
    chk(irq_o, 1'b0, "R5 irq removed by clear");

    // R5: enable set after the event
    wr(3'b000);
    stop_main();
    cyc(30);
    expect_rd(3'b101, "R2 flag without enable");
    wr(3'b010);
    expect_rd(3'b111, "R5 late enable");
    cyc(3);
    chk(irq_o, 1'b0, "R5 no irq for late enable");
    main_run = 1'b1;
    cyc(100);
    wr(3'b011);
    expect_rd(3'b010, "R3 R4 back and cleared");

    // R8: halt freezes
    halt_i = 1'b1;
    cyc(2);
    stop_main();
    cyc(40);
    expect_rd(3'b010, "R8 no switch in halt");
    wr(3'b000);
    expect_rd(3'b010, "R8 write ignored in halt");
    wait_i = 1'b1;
    cyc(2);
    chk(wake_o, 1'b0, "R7 no wake in halt");
    chk(irq_o, 1'b0, "R8 no irq in halt");
    wait_i = 1'b0;
    main_run = 1'b1;
    cyc(10);
    halt_i = 1'b0;
    cyc(40);
    expect_rd(3'b010, "R8 config kept after halt");
    chk_core_main("R8 core still on main");

    // R9: reset during halt
    halt_i = 1'b1;
    cyc(2);
    rst = 1'b1;
    cyc(4);
    rst = 1'b0;
    cyc(2);
    expect_rd(3'b000, "R9 reset during halt");
    halt_i = 1'b0;
    cyc(10);
    report();
  end
endmodule